// File: doc/BRIEF.md
# Worker Shared-RAM Access Controller

This block sits between one controller CPU and a set of worker nodes (eight by default). Each worker owns a single-port RAM of 256 bytes, enough for four rows of 64 one-byte cells. In normal operation the worker's own bus drives that RAM. To read or change a worker's memory, the controller waits until the worker has halted and then takes the RAM for itself. It accesses the memory, gives the RAM back, and wakes the worker with a one-cycle interrupt pulse. The block holds all of the RAMs, steers each RAM's single port to one of its two users, and runs the handshake lines that go to each worker.

The controller drives the block through a one-cycle command port and a memory port. The command port carries an operation and a worker index. The memory port carries the address, write data, a write strobe and a broadcast flag. When the broadcast flag is set, a write lands in every worker RAM at once, while reads still come from the one worker that has been taken. The block protects each worker in three ways:

- A take aimed at a running worker is refused and reported.
- A worker that is cut off from its RAM reads the all-ones byte, which that CPU decodes as a halt instruction.
- A halt request only asks the worker to stop. It never removes the worker from its bus.

Each worker has its own state machine with four states:

- `NODE_LOCAL`: the worker owns its RAM.
- `NODE_ASK`: a halt request is pending.
- `NODE_OWNED`: the controller owns the RAM.
- `NODE_WAKE`: one cycle with the interrupt raised.

The transitions are:

| Transition | Cause |
|---|---|
| LOCAL→OWNED, ASK→OWNED | take accepted |
| LOCAL→ASK | halt request to a running worker |
| ASK→LOCAL | the worker reports halted |
| OWNED→WAKE | release |
| WAKE→LOCAL | always, after one cycle |
| any state→LOCAL | worker reset command |

Top module: `wsr_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all take bits are 0, interrupt and halt-request lines are 0, the worker reset line is 0, `take_err` is 0 and `ctl_rdata` is 0xFF.
- R2: A worker that is not taken reads and writes its own RAM. A read returns `mem[addr]` in the cycle after the address is presented. A read in the same cycle as a write to the same address returns the old data.
- R3: A TAKE command (op 1) to a halted worker, given while no worker is taken, sets that worker's take bit in the cycle after the command. At most one take bit is ever set. This holds for every index, including the highest.
- R4: A TAKE command is refused in two cases: the target's run input is 1, or another worker is already taken. A refusal pulses `take_err` for exactly one cycle and leaves all take bits unchanged.
- R5: While a worker is taken, its local read data is 0xFF, one cycle after each address.
- R6: While a worker is taken, a controller write stores into that worker's RAM. `ctl_rdata` returns that RAM's byte one cycle after the address.
- R7: With no worker taken, `ctl_rdata` is 0xFF, and a controller write with broadcast clear is dropped.
- R8: A controller write with broadcast set stores into every worker RAM in that cycle. Any worker reading in that cycle gets 0xFF. Controller reads still come only from the taken worker.
- R9: A RELEASE command (op 2) to a taken worker clears its take bit and raises its interrupt for exactly one cycle, both in the cycle after the command. A RELEASE to a worker that is not taken has no effect.
- R10: A HALTREQ command (op 3) to a running worker raises its halt-request line. The line stays high while the run input stays 1 and drops in the cycle after the run input is sampled 0. It does not change RAM ownership. A HALTREQ to a halted worker has no effect.
- R11: A RESETW command (op 4) pulses `wk_rst` for one cycle, returns every worker to local ownership and raises no interrupt.
- R12: Op 0 and ops 5 to 7 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Command: 0 none, 1 TAKE, 2 RELEASE, 3 HALTREQ, 4 RESETW |
| cmd_id | input | IDW (3) | Target worker index |
| ctl_addr | input | AW (8) | Controller memory address |
| ctl_wdata | input | DW (8) | Controller write data |
| ctl_we | input | 1 | Controller write strobe |
| ctl_bcast | input | 1 | Broadcast-write flag |
| ctl_rdata | output | DW (8) | Read data from the taken worker, or 0xFF |
| take_err | output | 1 | One-cycle pulse when a TAKE is refused |
| wk_run | input | NW (8) | Per-worker status: 1 running, 0 halted |
| wk_addr | input | NW*AW (64) | Worker addresses, worker i at bits [i*AW +: AW] |
| wk_wdata | input | NW*DW (64) | Worker write data, packed the same way |
| wk_we | input | NW (8) | Worker write strobes |
| wk_rdata | output | NW*DW (64) | Worker read data, packed the same way |
| wk_take | output | NW (8) | Per-worker take bits |
| wk_irq | output | NW (8) | Per-worker wake interrupt pulses |
| wk_hreq | output | NW (8) | Per-worker halt-request lines |
| wk_rst | output | 1 | Worker reset pulse |

## Verification
A broadcast write and a local fetch by a running worker can fall in the same cycle. In that cycle the broadcast takes the worker's RAM port away. The bench provokes this by holding worker 6 running with a read at the broadcast address while the controller issues a broadcast write to that address. It then checks two things: worker 6 sees 0xFF in the cycle after the broadcast, and it sees the broadcast byte in the cycle after that. The same bench also checks that the taken worker's controller read and the untaken workers' local reads return that byte.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_TAKE    = 3'd1,
        OP_RELEASE = 3'd2,
        OP_HALTREQ = 3'd3,
        OP_RESETW  = 3'd4
    } wsr_op_e;

    typedef enum logic [1:0] {
        NODE_LOCAL = 2'd0,
        NODE_ASK   = 2'd1,
        NODE_OWNED = 2'd2,
        NODE_WAKE  = 2'd3
    } node_state_e;

endpackage

// File: rtl/wsr_cmd_guard.sv
module wsr_cmd_guard
    import wsr_pkg::*;
#(
    parameter int NW  = 8,
    parameter int IDW = 3
) (
    input  logic [2:0]     cmd_op,
    input  logic [IDW-1:0] cmd_id,
    input  logic [NW-1:0]  wk_run,
    input  logic [NW-1:0]  owned,
    input  logic [NW-1:0]  takeable,
    output logic [NW-1:0]  take_go,
    output logic [NW-1:0]  rel_go,
    output logic [NW-1:0]  ask_go,
    output logic           rst_go,
    output logic           take_bad
);

    logic [NW-1:0] id_hit;
    logic          any_owned;
    logic          is_take;

    generate
        for (genvar i = 0; i < NW; i++) begin : g_hit
            assign id_hit[i] = (cmd_id == IDW'(i));
        end
    endgenerate

    always_comb begin
        any_owned = |owned;
        is_take   = (cmd_op == OP_TAKE);
        take_go   = {NW{is_take && !any_owned}} & id_hit & ~wk_run & takeable;
        rel_go    = {NW{cmd_op == OP_RELEASE}} & id_hit;
        ask_go    = {NW{cmd_op == OP_HALTREQ}} & id_hit & wk_run;
        rst_go    = (cmd_op == OP_RESETW);
        // refused: a take that neither lands nor targets the worker already held
        take_bad  = is_take && !(|(owned & id_hit)) && !(|take_go);
    end

endmodule

// File: rtl/wsr_node_fsm.sv
module wsr_node_fsm
    import wsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_go,
    input  logic rel_go,
    input  logic ask_go,
    input  logic rst_go,
    input  logic run,
    output logic take,
    output logic irq,
    output logic hreq,
    output logic takeable
);

    node_state_e state_q;
    node_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NODE_LOCAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (rst_go) begin
            state_d = NODE_LOCAL;
        end else begin
            unique case (state_q)
                NODE_LOCAL: begin
                    if (take_go)     state_d = NODE_OWNED;
                    else if (ask_go) state_d = NODE_ASK;
                end
                NODE_ASK: begin
                    if (take_go)   state_d = NODE_OWNED;
                    else if (!run) state_d = NODE_LOCAL;
                end
                NODE_OWNED: begin
                    if (rel_go) state_d = NODE_WAKE;
                end
                NODE_WAKE: state_d = NODE_LOCAL;
            endcase
        end
    end

    always_comb begin
        take     = 1'b0;
        irq      = 1'b0;
        hreq     = 1'b0;
        takeable = 1'b0;
        unique case (state_q)
            NODE_LOCAL: takeable = 1'b1;
            NODE_ASK: begin
                hreq     = 1'b1;
                takeable = 1'b1;
            end
            NODE_OWNED: take = 1'b1;
            NODE_WAKE:  irq  = 1'b1;
        endcase
    end

endmodule

// File: rtl/wsr_ram_bank.sv
module wsr_ram_bank #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_own,
    input  logic          ctl_we,
    input  logic [AW-1:0] ctl_addr,
    input  logic [DW-1:0] ctl_wdata,
    input  logic          wk_we,
    input  logic [AW-1:0] wk_addr,
    input  logic [DW-1:0] wk_wdata,
    output logic [DW-1:0] q_raw,
    output logic [DW-1:0] wk_rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] port_addr;
    logic [DW-1:0] port_wdata;
    logic          port_we;
    logic          own_q;

    always_comb begin
        port_addr  = ctl_own ? ctl_addr  : wk_addr;
        port_wdata = ctl_own ? ctl_wdata : wk_wdata;
        port_we    = ctl_own ? ctl_we    : wk_we;
    end

    always_ff @(posedge clk) begin
        q_raw <= mem[port_addr];
        if (port_we) mem[port_addr] <= port_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_q <= 1'b0;
        else        own_q <= ctl_own;
    end

    // a worker cut off from its RAM fetches all ones (halt opcode)
    assign wk_rdata = own_q ? {DW{1'b1}} : q_raw;

endmodule

// File: rtl/wsr_ctrl.sv
module wsr_ctrl
    import wsr_pkg::*;
#(
    parameter int NW = 8,
    parameter int AW = 8,
    parameter int DW = 8,
    localparam int IDW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_op,
    input  logic [IDW-1:0]   cmd_id,
    input  logic [AW-1:0]    ctl_addr,
    input  logic [DW-1:0]    ctl_wdata,
    input  logic             ctl_we,
    input  logic             ctl_bcast,
    output logic [DW-1:0]    ctl_rdata,
    output logic             take_err,
    input  logic [NW-1:0]    wk_run,
    input  logic [NW*AW-1:0] wk_addr,
    input  logic [NW*DW-1:0] wk_wdata,
    input  logic [NW-1:0]    wk_we,
    output logic [NW*DW-1:0] wk_rdata,
    output logic [NW-1:0]    wk_take,
    output logic [NW-1:0]    wk_irq,
    output logic [NW-1:0]    wk_hreq,
    output logic             wk_rst
);

    logic [NW-1:0]  take_go, rel_go, ask_go, takeable;
    logic           rst_go, take_bad;
    logic [DW-1:0]  q_raw [NW];
    logic [IDW-1:0] take_idx, sel_idx_q;
    logic           sel_valid_q;
    logic           bcast_wr;

    wsr_cmd_guard #(.NW(NW), .IDW(IDW)) u_guard (
        .cmd_op   (cmd_op),
        .cmd_id   (cmd_id),
        .wk_run   (wk_run),
        .owned    (wk_take),
        .takeable (takeable),
        .take_go  (take_go),
        .rel_go   (rel_go),
        .ask_go   (ask_go),
        .rst_go   (rst_go),
        .take_bad (take_bad)
    );

    assign bcast_wr = ctl_we && ctl_bcast;

    generate
        for (genvar i = 0; i < NW; i++) begin : g_node
            wsr_node_fsm u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .take_go  (take_go[i]),
                .rel_go   (rel_go[i]),
                .ask_go   (ask_go[i]),
                .rst_go   (rst_go),
                .run      (wk_run[i]),
                .take     (wk_take[i]),
                .irq      (wk_irq[i]),
                .hreq     (wk_hreq[i]),
                .takeable (takeable[i])
            );

            wsr_ram_bank #(.AW(AW), .DW(DW)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .ctl_own   (wk_take[i] || bcast_wr),
                .ctl_we    (ctl_we && (wk_take[i] || ctl_bcast)),
                .ctl_addr  (ctl_addr),
                .ctl_wdata (ctl_wdata),
                .wk_we     (wk_we[i]),
                .wk_addr   (wk_addr[i*AW +: AW]),
                .wk_wdata  (wk_wdata[i*DW +: DW]),
                .q_raw     (q_raw[i]),
                .wk_rdata  (wk_rdata[i*DW +: DW])
            );
        end
    endgenerate

    always_comb begin
        take_idx = '0;
        for (int k = 0; k < NW; k++) begin
            if (wk_take[k]) take_idx = IDW'(k);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_valid_q <= 1'b0;
            sel_idx_q   <= '0;
            take_err    <= 1'b0;
            wk_rst      <= 1'b0;
        end else begin
            sel_valid_q <= |wk_take;
            sel_idx_q   <= take_idx;
            take_err    <= take_bad;
            wk_rst      <= rst_go;
        end
    end

    assign ctl_rdata = sel_valid_q ? q_raw[sel_idx_q] : {DW{1'b1}};

endmodule

// File: rtl/wsr_ctrl_chk.sv
module wsr_ctrl_chk #(
    parameter int NW = 8,
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NW-1:0]    wk_run,
    input logic [NW-1:0]    wk_take,
    input logic [NW-1:0]    wk_irq,
    input logic [NW-1:0]    wk_hreq,
    input logic             wk_rst,
    input logic             take_err,
    input logic [DW-1:0]    ctl_rdata,
    input logic [NW*DW-1:0] wk_rdata
);

    assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wk_take));

    assert_refusal_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_err |-> $stable(wk_take));

    assert_idle_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|wk_take) |-> (ctl_rdata == {DW{1'b1}}));

    assert_reset_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wk_rst |-> (wk_take == '0 && wk_irq == '0));

    generate
        for (genvar i = 0; i < NW; i++) begin : g_w
            assert_take_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(wk_take[i]) |-> !$past(wk_run[i]));

            assert_dark_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $past(wk_take[i]) |-> (wk_rdata[i*DW +: DW] == {DW{1'b1}}));

            assert_wake_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(wk_irq[i]) |-> ($past(wk_take[i]) && !wk_take[i]));

            assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
                wk_irq[i] |=> !wk_irq[i]);

            assert_hreq_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(wk_hreq[i]) |-> $past(wk_run[i]));
        end
    endgenerate

endmodule

bind wsr_ctrl wsr_ctrl_chk #(.NW(NW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wk_run    (wk_run),
    .wk_take   (wk_take),
    .wk_irq    (wk_irq),
    .wk_hreq   (wk_hreq),
    .wk_rst    (wk_rst),
    .take_err  (take_err),
    .ctl_rdata (ctl_rdata),
    .wk_rdata  (wk_rdata)
);

// File: tb/test_wsr_ctrl.sv
`timescale 1ns/1ps
module test_wsr_ctrl;

    localparam int NW = 8;
    localparam int AW = 8;
    localparam int DW = 8;

    localparam int K_TAKE = 0, K_IRQ = 1, K_HREQ = 2, K_WRST = 3,
                   K_ERR = 4, K_CRD = 5, K_WRD = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cmd_op = 3'd0;
    logic [2:0]       cmd_id = 3'd0;
    logic [AW-1:0]    ctl_addr = '0;
    logic [DW-1:0]    ctl_wdata = '0;
    logic             ctl_we = 1'b0;
    logic             ctl_bcast = 1'b0;
    logic [DW-1:0]    ctl_rdata;
    logic             take_err;
    logic [NW-1:0]    wk_run = 8'b0100_1100;
    logic [NW*AW-1:0] wk_addr = '0;
    logic [NW*DW-1:0] wk_wdata = '0;
    logic [NW-1:0]    wk_we = '0;
    logic [NW*DW-1:0] wk_rdata;
    logic [NW-1:0]    wk_take, wk_irq, wk_hreq;
    logic             wk_rst;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    typedef struct {
        int          kind;
        int          idx;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t sbq[$];

    always #2.5 clk = ~clk;

    wsr_ctrl #(.NW(NW), .AW(AW), .DW(DW)) i_wsr_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_id(cmd_id),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_we(ctl_we),
        .ctl_bcast(ctl_bcast), .ctl_rdata(ctl_rdata), .take_err(take_err),
        .wk_run(wk_run), .wk_addr(wk_addr), .wk_wdata(wk_wdata), .wk_we(wk_we),
        .wk_rdata(wk_rdata), .wk_take(wk_take), .wk_irq(wk_irq),
        .wk_hreq(wk_hreq), .wk_rst(wk_rst)
    );

    function automatic logic [31:0] observe(int kind, int idx);
        case (kind)
            K_TAKE:  return 32'(wk_take);
            K_IRQ:   return 32'(wk_irq);
            K_HREQ:  return 32'(wk_hreq);
            K_WRST:  return 32'(wk_rst);
            K_ERR:   return 32'(take_err);
            K_CRD:   return 32'(ctl_rdata);
            default: return 32'(wk_rdata[idx*DW +: DW]);
        endcase
    endfunction

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            exp_t e;
            logic [31:0] act;
            e   = sbq.pop_front();
            act = observe(e.kind, e.idx);
            n_checks++;
            if (act !== e.val) begin
                n_fails++;
                $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                         e.req, e.kind, e.idx, act, e.val);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic want(int kind, int idx, logic [31:0] val, string req);
        exp_t e;
        e.kind = kind; e.idx = idx; e.val = val; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic cmd(int op, int id);
        cmd_op = 3'(op);
        cmd_id = 3'(id);
        tick();
        cmd_op = 3'd0;
    endtask

    task automatic wk_read(int w, int a);
        wk_addr[w*AW +: AW] = AW'(a);
        wk_we[w] = 1'b0;
    endtask

    task automatic wk_write(int w, int a, int d);
        wk_addr[w*AW +: AW]  = AW'(a);
        wk_wdata[w*DW +: DW] = DW'(d);
        wk_we[w] = 1'b1;
        tick();
        wk_we[w] = 1'b0;
    endtask

    task automatic ctl_write(int a, int d, bit bc);
        ctl_addr  = AW'(a);
        ctl_wdata = DW'(d);
        ctl_bcast = bc;
        ctl_we    = 1'b1;
        tick();
        ctl_we    = 1'b0;
        ctl_bcast = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        // R1: reset state
        want(K_TAKE, 0, 0, "R1"); want(K_IRQ, 0, 0, "R1"); want(K_HREQ, 0, 0, "R1");
        want(K_WRST, 0, 0, "R1"); want(K_ERR, 0, 0, "R1"); want(K_CRD, 0, 32'hFF, "R1");
        rst_n = 1'b1;
        tick();
        want(K_TAKE, 0, 0, "R1"); want(K_CRD, 0, 32'hFF, "R1");

        // R2: local access on worker 2
        wk_write(2, 5, 8'h3C);
        wk_read(2, 5);
        tick();
        want(K_WRD, 2, 32'h3C, "R2");
        wk_write(0, 12, 8'h22);

        // R10: halt request on running worker 2
        cmd(3, 2);
        want(K_HREQ, 0, 32'h04, "R10"); want(K_TAKE, 0, 0, "R10");
        tick();
        want(K_HREQ, 0, 32'h04, "R10"); want(K_WRD, 2, 32'h3C, "R10");
        wk_run[2] = 1'b0;
        tick();
        want(K_HREQ, 0, 0, "R10");
        cmd(3, 4);
        want(K_HREQ, 0, 0, "R10");

        // R4: take on running worker 3
        cmd(1, 3);
        want(K_ERR, 0, 1, "R4"); want(K_TAKE, 0, 0, "R4");
        tick();
        want(K_ERR, 0, 0, "R4");

        // R3: take halted worker 2
        cmd(1, 2);
        want(K_TAKE, 0, 32'h04, "R3"); want(K_ERR, 0, 0, "R3");

        // R5: worker 2 sees all ones
        tick();
        want(K_WRD, 2, 32'hFF, "R5");

        // R6: controller read and write
        ctl_addr = 8'd5;
        tick();
        want(K_CRD, 0, 32'h3C, "R6");
        ctl_write(6, 8'hA5, 1'b0);
        tick();
        want(K_CRD, 0, 32'hA5, "R6");

        // R4: second take while one is held
        cmd(1, 4);
        want(K_ERR, 0, 1, "R4"); want(K_TAKE, 0, 32'h04, "R4");

        // R8: broadcast write collides with running worker 6 fetch
        wk_read(6, 9);
        ctl_write(9, 8'h77, 1'b1);
        want(K_WRD, 6, 32'hFF, "R8");
        tick();
        want(K_CRD, 0, 32'h77, "R8"); want(K_WRD, 6, 32'h77, "R8");

        // R9: release and wake
        cmd(2, 2);
        want(K_TAKE, 0, 0, "R9"); want(K_IRQ, 0, 32'h04, "R9");
        tick();
        want(K_IRQ, 0, 0, "R9");
        wk_read(2, 6); wk_read(5, 9); wk_read(0, 9);
        tick();
        want(K_WRD, 2, 32'hA5, "R6"); want(K_WRD, 5, 32'h77, "R8");
        want(K_WRD, 0, 32'h77, "R8");
        cmd(2, 4);
        want(K_IRQ, 0, 0, "R9"); want(K_TAKE, 0, 0, "R9");

        // R7: idle controller port
        ctl_addr = 8'd12;
        tick();
        want(K_CRD, 0, 32'hFF, "R7");
        ctl_write(12, 8'h11, 1'b0);
        wk_read(0, 12);
        tick();
        want(K_WRD, 0, 32'h22, "R7");

        // R11: worker reset while worker 0 is taken
        cmd(1, 0);
        want(K_TAKE, 0, 32'h01, "R3");
        cmd(4, 0);
        want(K_WRST, 0, 1, "R11"); want(K_TAKE, 0, 0, "R11"); want(K_IRQ, 0, 0, "R11");
        tick();
        want(K_WRST, 0, 0, "R11");

        // R3/R9: highest index
        cmd(1, 7);
        want(K_TAKE, 0, 32'h80, "R3");
        ctl_write(0, 8'h5A, 1'b0);
        tick();
        want(K_CRD, 0, 32'h5A, "R6");
        cmd(2, 7);
        want(K_IRQ, 0, 32'h80, "R9"); want(K_TAKE, 0, 0, "R9");

        // R12: unused op codes
        cmd(7, 1);
        want(K_TAKE, 0, 0, "R12"); want(K_ERR, 0, 0, "R12");
        want(K_IRQ, 0, 0, "R12"); want(K_HREQ, 0, 0, "R12");
        want(K_WRST, 0, 0, "R12");

        repeat (3) tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule